// File: doc/BRIEF.md
# Event-Weighted Core Power Estimator

This block turns a core's per-cycle activity into a single estimate of its switching power. Every cycle it receives a vector of one-cycle event pulses, one pulse line per event type. Examples are cache misses, floating-point operations, branch mispredictions and register file accesses. Each asserted line contributes its own programmable weight. The contributions of all lines are added and then accumulated over a sampling window whose length is given in cycles.

When the window closes, a clock-tree term is added once. This term comes from a small table and is chosen by the current frequency-step input. The result is latched as the proxy value, a one-cycle strobe marks it, and a capping flag reports whether it exceeds a programmable limit. The accumulator then restarts from zero.

Weights, clock-tree terms and the limit are loaded through a write-only configuration port. A power-management controller reads the proxy and the flag at each strobe and steers frequency, voltage or capping from them.

Top module: `power_proxy`

## Requirements
- R1: While reset is held, and in the cycle after its release, proxy_value, proxy_valid and over_limit are all 0. All weights, clock-tree terms and the limit reset to 0.
- R2: proxy_valid is high for exactly one cycle at the end of every window of window_len cycles. Outside that cycle it stays low. A window_len of 0 behaves as 1, which gives a strobe every cycle.
- R3: At the strobe, proxy_value equals the sum, over every cycle of the window just closed, of the weights of the asserted event lines. The clock-tree term is added to this sum.
- R4: Each event line i (0 to 51) has its own weight, written at configuration address i from the low 8 bits of cfg_wdata.
- R5: Clock-tree terms for frequency steps 0 to 3 are written at addresses 52 to 55. The term used is the one selected by freq_step in the window's last cycle, and it is added exactly once per window.
- R6: The running total saturates at 2^20-1 (1048575) and does not wrap. This holds for the event sum and for the clock-tree addition.
- R7: At the strobe, over_limit is 1 exactly when proxy_value is greater than the limit held in the window's last cycle. The limit is written at address 56. Between strobes over_limit holds its value, even when the limit is rewritten mid-window.
- R8: Each window starts from zero. Nothing from a previous window carries into the next proxy value.
- R9: Writes to addresses 57 to 63 change no weight, term or limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_pulse | input | 52 | One-cycle activity event pulses |
| freq_step | input | 2 | Current frequency step, selects the clock-tree term |
| window_len | input | 16 | Sampling window length in cycles (0 treated as 1) |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 6 | Configuration address |
| cfg_wdata | input | 20 | Configuration write data |
| proxy_value | output | 20 | Latched power proxy of the last window |
| proxy_valid | output | 1 | One-cycle strobe when proxy_value updates |
| over_limit | output | 1 | Proxy above limit, updated at strobes only |

## Verification
The summation is exercised with four event patterns. One event at a time over distinct lines shows that each line reaches its own weight. All lines at once shows the full adder width. An even-lines-only pattern would expose swapped or shifted weights. An idle window shows the clock-tree term alone and that nothing carries over between windows. Different frequency steps pick different table entries. A long window of maximum-weight activity drives the total into saturation. A mid-window limit rewrite separates a flag that updates at the boundary from one that follows the limit live. One-cycle and zero-length windows check the strobe cadence.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    REG_WEIGHT = 2'd0,
    REG_CTREE  = 2'd1,
    REG_LIMIT  = 2'd2,
    REG_NONE   = 2'd3
  } pp_region_e;
endpackage

// File: rtl/pp_cfg_regs.sv
module pp_cfg_regs
  import pp_pkg::*;
#(
  parameter int N_EVT   = 52,
  parameter int WT_W    = 8,
  parameter int N_FSTEP = 4,
  parameter int ACC_W   = 20,
  parameter int ADDR_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [ACC_W-1:0]         cfg_wdata,
  output logic [N_EVT*WT_W-1:0]    weights,
  output logic [N_FSTEP*ACC_W-1:0] ctree_tbl,
  output logic [ACC_W-1:0]         limit
);
  localparam int CT_BASE  = N_EVT;
  localparam int LIM_ADDR = N_EVT + N_FSTEP;

  pp_region_e region;
  logic       lim_en;

  // Address decode: weights, then clock-tree terms, then the limit.
  always_comb begin
    region = REG_NONE;
    if (cfg_addr < ADDR_W'(CT_BASE))       region = REG_WEIGHT;
    else if (cfg_addr < ADDR_W'(LIM_ADDR)) region = REG_CTREE;
    else if (cfg_addr == ADDR_W'(LIM_ADDR)) region = REG_LIMIT;
    lim_en = cfg_we && (region == REG_LIMIT);
  end

  for (genvar i = 0; i < N_EVT; i++) begin : g_wt
    logic             wt_en;
    logic [WT_W-1:0]  wt_q;
    always_comb wt_en = cfg_we && (region == REG_WEIGHT) && (cfg_addr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     wt_q <= '0;
      else if (wt_en) wt_q <= cfg_wdata[WT_W-1:0];
    end
    assign weights[i*WT_W +: WT_W] = wt_q;
  end

  for (genvar j = 0; j < N_FSTEP; j++) begin : g_ct
    logic              ct_en;
    logic [ACC_W-1:0]  ct_q;
    always_comb ct_en = cfg_we && (region == REG_CTREE) && (cfg_addr == ADDR_W'(CT_BASE + j));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ct_q <= '0;
      else if (ct_en) ct_q <= cfg_wdata;
    end
    assign ctree_tbl[j*ACC_W +: ACC_W] = ct_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      limit <= '0;
    else if (lim_en) limit <= cfg_wdata;
  end
endmodule

// File: rtl/pp_event_sum.sv
module pp_event_sum #(
  parameter int N_EVT = 52,
  parameter int WT_W  = 8,
  parameter int SUM_W = WT_W + $clog2(N_EVT + 1)
) (
  input  logic [N_EVT-1:0]      evt,
  input  logic [N_EVT*WT_W-1:0] weights,
  output logic [SUM_W-1:0]      sum
);
  logic [SUM_W-1:0] term [N_EVT];

  for (genvar i = 0; i < N_EVT; i++) begin : g_term
    assign term[i] = evt[i] ? SUM_W'(weights[i*WT_W +: WT_W]) : '0;
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < N_EVT; i++) sum = sum + term[i];
  end
endmodule

// File: rtl/pp_window_acc.sv
module pp_window_acc #(
  parameter int ACC_W = 20,
  parameter int SUM_W = 14,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUM_W-1:0] sum,
  input  logic [ACC_W-1:0] ctree,
  input  logic [ACC_W-1:0] limit,
  input  logic [LEN_W-1:0] len,
  output logic [ACC_W-1:0] proxy,
  output logic             valid,
  output logic             over,
  output logic [ACC_W-1:0] acc
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [LEN_W-1:0] cnt_q, cnt_d, last_idx;
  logic [ACC_W-1:0] acc_q, acc_d, proxy_q, proxy_d;
  logic             valid_q, valid_d, over_q, over_d;
  logic             at_end;
  logic [ACC_W+1:0] raw;
  logic [ACC_W-1:0] clipped;

  always_comb begin
    last_idx = (len == '0) ? '0 : len - 1'b1;
    at_end   = (cnt_q >= last_idx);
    raw      = {2'b00, acc_q} + (ACC_W+2)'(sum) + (at_end ? {2'b00, ctree} : '0);
    clipped  = (raw > {2'b00, ACC_MAX}) ? ACC_MAX : raw[ACC_W-1:0];
    cnt_d    = at_end ? '0 : cnt_q + 1'b1;
    acc_d    = at_end ? '0 : clipped;
    proxy_d  = at_end ? clipped : proxy_q;
    valid_d  = at_end;
    over_d   = at_end ? (clipped > limit) : over_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      proxy_q <= '0;
      valid_q <= 1'b0;
      over_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
      proxy_q <= proxy_d;
      valid_q <= valid_d;
      over_q  <= over_d;
    end
  end

  assign proxy = proxy_q;
  assign valid = valid_q;
  assign over  = over_q;
  assign acc   = acc_q;
endmodule

// File: rtl/power_proxy.sv
module power_proxy #(
  parameter int N_EVT   = 52,
  parameter int WT_W    = 8,
  parameter int N_FSTEP = 4,
  parameter int ACC_W   = 20,
  parameter int LEN_W   = 16,
  parameter int ADDR_W  = $clog2(N_EVT + N_FSTEP + 1),
  parameter int FSEL_W  = $clog2(N_FSTEP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  evt_pulse,
  input  logic [FSEL_W-1:0] freq_step,
  input  logic [LEN_W-1:0]  window_len,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [ACC_W-1:0]  cfg_wdata,
  output logic [ACC_W-1:0]  proxy_value,
  output logic              proxy_valid,
  output logic              over_limit
);
  localparam int SUM_W = WT_W + $clog2(N_EVT + 1);

  logic                     rst_meta, rst_sync;
  logic [N_EVT*WT_W-1:0]    weights;
  logic [N_FSTEP*ACC_W-1:0] ctree_tbl;
  logic [ACC_W-1:0]         limit_q;
  logic [ACC_W-1:0]         ctree_sel;
  logic [SUM_W-1:0]         evt_sum;
  logic [ACC_W-1:0]         acc_q;

  // Reset asserts at once and leaves after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  pp_cfg_regs #(
    .N_EVT(N_EVT), .WT_W(WT_W), .N_FSTEP(N_FSTEP), .ACC_W(ACC_W), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_sync), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .weights(weights), .ctree_tbl(ctree_tbl), .limit(limit_q)
  );

  pp_event_sum #(.N_EVT(N_EVT), .WT_W(WT_W), .SUM_W(SUM_W)) u_sum (
    .evt(evt_pulse), .weights(weights), .sum(evt_sum)
  );

  assign ctree_sel = ctree_tbl[freq_step*ACC_W +: ACC_W];

  pp_window_acc #(.ACC_W(ACC_W), .SUM_W(SUM_W), .LEN_W(LEN_W)) u_acc (
    .clk(clk), .rst_n(rst_sync), .sum(evt_sum), .ctree(ctree_sel), .limit(limit_q),
    .len(window_len), .proxy(proxy_value), .valid(proxy_valid), .over(over_limit),
    .acc(acc_q)
  );
endmodule

// File: rtl/power_proxy_chk.sv
module power_proxy_chk #(
  parameter int ACC_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid,
  input logic [ACC_W-1:0] proxy,
  input logic             over,
  input logic [ACC_W-1:0] limit,
  input logic [ACC_W-1:0] acc
);
  p_proxy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(proxy));

  p_over_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(over));

  p_over_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (over == (proxy > $past(limit))));

  p_window_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (acc == '0));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> (valid || (acc >= $past(acc))));
endmodule

bind power_proxy power_proxy_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(proxy_valid), .proxy(proxy_value),
  .over(over_limit), .limit(limit_q), .acc(acc_q)
);

// File: tb/test_power_proxy.sv
module test_power_proxy;
  localparam int  NE  = 52;
  localparam longint MAXV = 1048575;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] evt_pulse = '0;
  logic [1:0]    freq_step = '0;
  logic [15:0]   window_len = 16'd8;
  logic          cfg_we = 1'b0;
  logic [5:0]    cfg_addr = '0;
  logic [19:0]   cfg_wdata = '0;
  logic [19:0]   proxy_value;
  logic          proxy_valid;
  logic          over_limit;

  int n_chk = 0, n_bad = 0, cycles = 0;
  longint wt[NE];
  longint ct[4];
  longint lim;

  always #10 clk = ~clk;

  power_proxy i_power_proxy (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .freq_step(freq_step),
    .window_len(window_len), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .proxy_value(proxy_value), .proxy_valid(proxy_valid),
    .over_limit(over_limit)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [NE-1:0] pat(input int mode, input int k);
    logic [NE-1:0] v = '0;
    case (mode)
      0: v[k % NE] = 1'b1;
      1: v = '1;
      2: for (int i = 0; i < NE; i += 2) v[i] = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic longint wsum(input logic [NE-1:0] v);
    longint s = 0;
    for (int i = 0; i < NE; i++) if (v[i]) s += wt[i];
    return s;
  endfunction

  task automatic cfg_write(input int addr, input longint data);
    cfg_we = 1'b1; cfg_addr = 6'(addr); cfg_wdata = 20'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr < NE) wt[addr] = data & 255;
    else if (addr < NE + 4) ct[addr - NE] = data;
    else if (addr == NE + 4) lim = data;
  endtask

  task automatic sync_window();
    evt_pulse = '0;
    do @(negedge clk); while (!proxy_valid);
  endtask

  // Starts in the strobe cycle of the previous window; ends in this window's strobe cycle.
  task automatic run_window(input string req, input int len, input int mode, input int fs,
                            input int wr_k, input int wr_addr, input longint wr_data);
    longint acc_e = 0, exp_p;
    int n = (len == 0) ? 1 : len;
    logic prev_over = over_limit;
    window_len = 16'(len);
    freq_step = 2'(fs);
    for (int k = 0; k < n; k++) begin
      evt_pulse = pat(mode, k);
      acc_e += wsum(pat(mode, k));
      if (acc_e > MAXV) acc_e = MAXV;
      if (k == wr_k) begin
        cfg_we = 1'b1; cfg_addr = 6'(wr_addr); cfg_wdata = 20'(wr_data);
        if (wr_addr == NE + 4) lim = wr_data;
      end else cfg_we = 1'b0;
      @(negedge clk);
      if (k < n - 1) begin
        if (proxy_valid) check({req, " R2 strobe early"}, 1, 0);
        if (wr_k >= 0 && k >= wr_k) check({req, " R7 flag held"}, over_limit, prev_over);
      end
    end
    cfg_we = 1'b0;
    evt_pulse = '0;
    exp_p = acc_e + ct[fs];
    if (exp_p > MAXV) exp_p = MAXV;
    check({req, " R2 strobe"}, proxy_valid, 1);
    check({req, " R3 proxy"}, proxy_value, exp_p);
    check({req, " R7 flag"}, over_limit, (exp_p > lim) ? 1 : 0);
  endtask

  task automatic t_reset();
    check("R1 proxy at reset", proxy_value, 0);
    check("R1 valid at reset", proxy_valid, 0);
    check("R1 flag at reset", over_limit, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 proxy after release", proxy_value, 0);
    check("R1 valid after release", proxy_valid, 0);
    sync_window();
    check("R1 zero config proxy", proxy_value, 0);
    check("R1 zero config flag", over_limit, 0);
  endtask

  task automatic t_config();
    for (int i = 0; i < NE; i++) cfg_write(i, i + 1);
    for (int j = 0; j < 4; j++) cfg_write(NE + j, 100 * (j + 1));
    cfg_write(NE + 4, 500);
    sync_window();
  endtask

  initial begin
    for (int i = 0; i < NE; i++) wt[i] = 0;
    for (int j = 0; j < 4; j++) ct[j] = 0;
    lim = 0;
    repeat (3) @(negedge clk);
    t_reset();
    t_config();
    run_window("R4 single events", 8, 0, 0, -1, 0, 0);
    run_window("R4 even events", 3, 2, 1, -1, 0, 0);
    run_window("R5 all events step2", 4, 1, 2, -1, 0, 0);
    run_window("R8 idle window", 5, 3, 1, -1, 0, 0);
    run_window("R7 limit rewrite", 8, 3, 3, 2, NE + 4, 300);
    run_window("R2 len one", 1, 3, 0, -1, 0, 0);
    run_window("R2 len one again", 1, 0, 0, -1, 0, 0);
    run_window("R2 len zero", 0, 3, 2, -1, 0, 0);
    window_len = 16'd4;
    for (int i = 0; i < NE; i++) cfg_write(i, 255);
    sync_window();
    run_window("R6 saturation", 100, 1, 3, -1, 0, 0);
    check("R6 saturated value", proxy_value, MAXV);
    for (int a = NE + 5; a < 64; a++) cfg_write(a, 0);
    sync_window();
    run_window("R9 ignored addresses", 2, 1, 0, -1, 0, 0);
    run_window("R8 after saturation", 3, 3, 1, -1, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule